// File: doc/BRIEF.md
# Four-Window Page Mapper

This block widens a 16-bit processor address into a 22-bit physical address. The processor space is split into four 16K windows. Each window has its own 8-bit page register, and that register supplies the upper physical bits for any access that falls inside the window. The processor loads the page registers, and the enable flag, with I/O writes to parameterised ports. It can read all of them back with I/O reads.

After reset the mapper is switched off. While it is off, the upper physical bits read as all ones, as if a floating bus were held high by pull-ups, so boot code runs from the top region of physical space. Software loads all four page registers first and then sets the enable flag with a separate write. A bypass input sends selected accesses to the same all-ones common area while the mapper is on. A parameter can add a built-in bypass for processor addresses whose bits 15:8 are all zero.

Three physical address bits (19:17) are decoded into eight 128K region selects. Region 0 is RAM and region 7 is ROM. The selects are active only while the memory request is high. Physical address and region selects are registered and appear one clock after the inputs.

Top module: `win_page_mapper`

## Requirements
- R1: Processor address bits 15:14 choose page register k (k = 0..3), and that register's 8 bits appear on physical address bits 21:14 while the mapper is enabled.
- R2: Physical address bits 13:0 always equal processor address bits 13:0.
- R3: An I/O write to port PAGE_PORT_BASE+k loads io_wdata into page register k only. An I/O write to any port outside the page ports and the control port changes no page register.
- R4: Reset clears the enable flag. While the flag is clear, physical bits 21:14 are all ones.
- R5: An I/O write to CTRL_PORT sets the enable flag to io_wdata bit 0. Switching the mapper off and on again leaves the page registers unchanged.
- R6: region_sel is one-hot, and bit n is set when physical bits 19:17 equal n. Region 0 is RAM and region 7 is ROM, so a disabled mapper selects region 7 (region_sel = 8'h80).
- R7: region_sel is all zeros whenever mem_req is low.
- R8: While bypass is high, physical bits 21:14 are all ones even if the mapper is enabled.
- R9: An I/O read returns data one clock later on io_rdata. A page port returns its register, CTRL_PORT returns {7'b0, enable}, and any other port returns 0.
- R10: phys_addr and region_sel follow their inputs after exactly one clock edge and hold their previous values until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| mem_req | input | 1 | Memory request, active high |
| bypass | input | 1 | Routes this access to the all-ones common area |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, registered |
| phys_addr | output | 22 | Physical address, registered |
| region_sel | output | 8 | 128K region selects, one-hot, registered |

## Verification
The page registers are loaded with four distinct values. Their bits 19:17 map to regions 0, 2, 4 and 7, so a window that picks the wrong register shows up in both the address and the region select. Each window is accessed at its lowest and highest offset and at a mixed offset, which separates a window-select fault from a pass-through fault. Writes to an unrelated port and an off/on toggle of the enable flag show that the registers are retained. Bypass and mem_req low are tried with the mapper enabled, so a forced all-ones result or suppressed selects cannot come from a disabled mapper.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

  // Turn a region index into a one-hot select vector.
  function automatic logic [7:0] region_onehot(input logic [2:0] idx);
    logic [7:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/wpm_page_bank.sv
module wpm_page_bank #(
  parameter int NWIN           = 4,
  parameter int PAGE_W         = 8,
  parameter int PORT_W         = 8,
  parameter int DATA_W         = 8,
  parameter int PAGE_PORT_BASE = 8'h10,
  parameter int CTRL_PORT      = 8'h14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         io_wr,
  input  logic                         io_rd,
  input  logic [PORT_W-1:0]            io_port,
  input  logic [DATA_W-1:0]            io_wdata,
  output logic [NWIN-1:0][PAGE_W-1:0]  pages,
  output logic                         map_on,
  output logic [DATA_W-1:0]            io_rdata
);

  localparam logic [PORT_W-1:0] BASE_P = PORT_W'(PAGE_PORT_BASE);
  localparam logic [PORT_W-1:0] CTRL_P = PORT_W'(CTRL_PORT);
  localparam int                IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic [PORT_W-1:0] offset;
  logic              page_hit;
  logic              ctrl_hit;

  assign offset   = io_port - BASE_P;
  assign page_hit = (io_port >= BASE_P) && (offset < PORT_W'(NWIN));
  assign ctrl_hit = (io_port == CTRL_P);

  // Page registers have no reset, so they can map to plain fabric flops.
  for (genvar k = 0; k < NWIN; k++) begin : g_page
    logic sel_k;
    assign sel_k = io_wr && page_hit && (offset[IDX_W-1:0] == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (sel_k) pages[k] <= io_wdata[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   map_on <= 1'b0;
    else if (io_wr && ctrl_hit) map_on <= io_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (io_rd) begin
      if (page_hit)      io_rdata <= DATA_W'(pages[offset[IDX_W-1:0]]);
      else if (ctrl_hit) io_rdata <= DATA_W'(map_on);
      else               io_rdata <= '0;
    end
  end

  // R5: the control write lands in the enable flag on the next edge
  a_r5_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    (io_wr && ctrl_hit) |=> (map_on == $past(io_wdata[0])));

  // R3: without a write strobe no page register moves
  a_r3_pages_hold: assert property (@(posedge clk) disable iff (rst)
    !io_wr |=> $stable(pages));

  // R4: the flag is clear on the first edge after reset
  a_r4_reset_off: assert property (@(posedge clk)
    rst |=> !map_on);

endmodule

// File: rtl/wpm_xlate.sv
module wpm_xlate #(
  parameter int CPU_AW          = 16,
  parameter int WIN_BITS        = 2,
  parameter int PAGE_W          = 8,
  parameter int REGION_LSB      = 17,
  parameter bit LOW_PAGE_COMMON = 1'b0,
  localparam int NWIN           = 1 << WIN_BITS,
  localparam int OFF_W          = CPU_AW - WIN_BITS,
  localparam int PHYS_AW        = OFF_W + PAGE_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CPU_AW-1:0]            cpu_addr,
  input  logic                         mem_req,
  input  logic                         bypass,
  input  logic                         map_on,
  input  logic [NWIN-1:0][PAGE_W-1:0]  pages,
  output logic [PHYS_AW-1:0]           phys_addr,
  output logic [7:0]                   region_sel
);

  import wpm_pkg::*;

  logic [WIN_BITS-1:0] win;
  logic [OFF_W-1:0]    off;
  logic                common_hit;
  logic                use_map;
  logic [PAGE_W-1:0]   upper;
  logic [PHYS_AW-1:0]  phys_d;
  logic [7:0]          region_d;

  assign win = cpu_addr[CPU_AW-1 -: WIN_BITS];
  assign off = cpu_addr[OFF_W-1:0];

  // Optional built-in bypass for the bottom 256 bytes.
  if (LOW_PAGE_COMMON) begin : g_low_common
    assign common_hit = (cpu_addr[CPU_AW-1:8] == '0);
  end else begin : g_no_low_common
    assign common_hit = 1'b0;
  end

  assign use_map  = map_on && !bypass && !common_hit;
  assign upper    = use_map ? pages[win] : '1;
  assign phys_d   = {upper, off};
  assign region_d = mem_req ? region_onehot(phys_d[REGION_LSB +: 3]) : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr  <= '0;
      region_sel <= '0;
    end else begin
      phys_addr  <= phys_d;
      region_sel <= region_d;
    end
  end

  // R4: a disabled mapper drives the upper bits high
  a_r4_off_ones: assert property (@(posedge clk) disable iff (rst)
    !map_on |=> (phys_addr[PHYS_AW-1:OFF_W] == '1));

  // R8: a bypassed access lands in the common area
  a_r8_bypass_ones: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (phys_addr[PHYS_AW-1:OFF_W] == '1));

  // R2: the low offset passes through one edge later
  a_r2_offset_pass: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phys_addr[OFF_W-1:0] == $past(cpu_addr[OFF_W-1:0])));

  // R7: no select without a memory request
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !mem_req |=> (region_sel == 8'h00));

  // R6: never more than one region selected
  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_sel));

endmodule

// File: rtl/win_page_mapper.sv
module win_page_mapper #(
  parameter int CPU_AW          = 16,
  parameter int WIN_BITS        = 2,
  parameter int PAGE_W          = 8,
  parameter int PORT_W          = 8,
  parameter int DATA_W          = 8,
  parameter int PAGE_PORT_BASE  = 8'h10,
  parameter int CTRL_PORT       = 8'h14,
  parameter int REGION_LSB      = 17,
  parameter bit LOW_PAGE_COMMON = 1'b0,
  localparam int NWIN           = 1 << WIN_BITS,
  localparam int PHYS_AW        = CPU_AW - WIN_BITS + PAGE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               mem_req,
  input  logic               bypass,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [PORT_W-1:0]  io_port,
  input  logic [DATA_W-1:0]  io_wdata,
  output logic [DATA_W-1:0]  io_rdata,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic [7:0]         region_sel
);

  logic [NWIN-1:0][PAGE_W-1:0] pages;
  logic                        map_on;

  wpm_page_bank #(
    .NWIN(NWIN), .PAGE_W(PAGE_W), .PORT_W(PORT_W), .DATA_W(DATA_W),
    .PAGE_PORT_BASE(PAGE_PORT_BASE), .CTRL_PORT(CTRL_PORT)
  ) bank_i (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd),
    .io_port(io_port), .io_wdata(io_wdata),
    .pages(pages), .map_on(map_on), .io_rdata(io_rdata)
  );

  wpm_xlate #(
    .CPU_AW(CPU_AW), .WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W),
    .REGION_LSB(REGION_LSB), .LOW_PAGE_COMMON(LOW_PAGE_COMMON)
  ) xlate_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mem_req(mem_req),
    .bypass(bypass), .map_on(map_on), .pages(pages),
    .phys_addr(phys_addr), .region_sel(region_sel)
  );

endmodule

// File: tb/win_page_mapper_tb_top.sv
module win_page_mapper_tb_top;

  localparam int CLK_P = 10;
  localparam logic [7:0] BASE = 8'h10;
  localparam logic [7:0] CTRL = 8'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        mem_req = 1'b0;
  logic        bypass = 1'b0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_port = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [21:0] phys_addr;
  logic [7:0]  region_sel;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [4];
  logic       mdl_on = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  win_page_mapper dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mem_req(mem_req),
    .bypass(bypass), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .phys_addr(phys_addr),
    .region_sel(region_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] exp_phys(input logic [15:0] a, input logic byp);
    logic [7:0] up;
    up = (mdl_on && !byp) ? mdl[a[15:14]] : 8'hFF;
    return {up, a[13:0]};
  endfunction

  function automatic logic [7:0] exp_region(input logic [21:0] p, input logic req);
    return req ? (8'h01 << p[19:17]) : 8'h00;
  endfunction

  task automatic io_write(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_port = port; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] port, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_port = port;
    @(negedge clk);
    d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic access(input string req, input logic [15:0] a,
                        input logic rq, input logic byp);
    logic [21:0] ep;
    @(negedge clk);
    cpu_addr = a; mem_req = rq; bypass = byp;
    @(negedge clk);
    ep = exp_phys(a, byp);
    chk({req, " phys"}, 32'(phys_addr), 32'(ep));
    chk({req, " region"}, 32'(region_sel), 32'(exp_region(ep, rq)));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    // R4 R6: disabled after reset, upper ones, ROM region
    access("R4 R6 reset state", 16'h1234, 1'b1, 1'b0);
    chk("R6 rom region", 32'(region_sel), 32'h80);
    io_read(CTRL, d);
    chk("R9 ctrl after reset", 32'(d), 32'h00);
  endtask

  task automatic t_load_pages();
    logic [7:0] vals [4] = '{8'h00, 8'h15, 8'hA3, 8'hFE};
    logic [7:0] d;
    for (int k = 0; k < 4; k++) begin
      io_write(BASE + 8'(k), vals[k]);
      mdl[k] = vals[k];
    end
    for (int k = 0; k < 4; k++) begin
      io_read(BASE + 8'(k), d);
      chk("R3 R9 page readback", 32'(d), 32'(vals[k]));
    end
    io_write(8'h20, 8'h5A);
    for (int k = 0; k < 4; k++) begin
      io_read(BASE + 8'(k), d);
      chk("R3 foreign port ignored", 32'(d), 32'(vals[k]));
    end
    io_read(8'h20, d);
    chk("R9 unmapped port reads zero", 32'(d), 32'h00);
    // still disabled: loading pages must not map anything
    access("R4 pages loaded but off", 16'h8000, 1'b1, 1'b0);
  endtask

  task automatic t_translate();
    logic [7:0] d;
    logic [13:0] offs [3] = '{14'h0000, 14'h3FFF, 14'h2A5C};
    io_write(CTRL, 8'h01);
    mdl_on = 1'b1;
    io_read(CTRL, d);
    chk("R9 R5 ctrl reads enabled", 32'(d), 32'h01);
    for (int w = 0; w < 4; w++)
      for (int o = 0; o < 3; o++)
        access("R1 R2 R6 mapped", {2'(w), offs[o]}, 1'b1, 1'b0);
    // window 0 holds page 0: RAM region; window 3 holds 0xFE: ROM region
    access("R6 ram region", 16'h0100, 1'b1, 1'b0);
    chk("R6 region0", 32'(region_sel), 32'h01);
    access("R6 rom region mapped", 16'hC000, 1'b1, 1'b0);
    chk("R6 region7", 32'(region_sel), 32'h80);
  endtask

  task automatic t_mreq_bypass();
    access("R7 no request", 16'h4321, 1'b0, 1'b0);
    chk("R7 selects low", 32'(region_sel), 32'h00);
    access("R8 bypass", 16'h4321, 1'b1, 1'b1);
    chk("R8 upper ones", 32'(phys_addr[21:14]), 32'hFF);
    access("R8 bypass released", 16'h4321, 1'b1, 1'b0);
  endtask

  task automatic t_toggle();
    logic [7:0] d;
    io_write(CTRL, 8'hFE);   // bit 0 clear: off
    mdl_on = 1'b0;
    access("R5 off", 16'h9ABC, 1'b1, 1'b0);
    io_write(CTRL, 8'h01);
    mdl_on = 1'b1;
    access("R5 on again keeps pages", 16'h9ABC, 1'b1, 1'b0);
    io_read(BASE + 8'd2, d);
    chk("R5 page retained", 32'(d), 32'hA3);
  endtask

  task automatic t_latency();
    logic [21:0] prev;
    access("R10 setup", 16'h4000, 1'b1, 1'b0);
    prev = phys_addr;
    @(negedge clk);
    cpu_addr = 16'hC123;
    #1;
    chk("R10 holds before edge", 32'(phys_addr), 32'(prev));
    @(negedge clk);
    chk("R10 updates after edge", 32'(phys_addr), 32'(exp_phys(16'hC123, 1'b0)));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_pages();
    t_translate();
    t_mreq_bypass();
    t_toggle();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule